// File: doc/BRIEF.md
# Multi-channel compare match timer

The block holds five independent timer channels behind a simple register bus. Each channel has an up-counter, a compare value that sets its period, and a control/status register. The control/status register selects the counting rate, the counter width (32-bit or 16-bit) and holds a sticky match flag. A common start register carries one run bit per channel. One free-running prescaler is shared by all channels. It offers three fixed divide ratios of the peripheral clock, and each channel picks one of them.

While a channel runs, its counter advances by one on each prescaled tick. On the tick where the active part of the counter equals the active part of the compare value, the counter returns to zero and the channel's match flag is raised. If that clear happens while the compare value is all ones in the active width, the channel also emits a one-cycle overflow pulse. Software clears a flag by writing zero to it. Reads return data one clock after the address is presented.

Top module: `match_timer`

Register map (byte addresses, bits 1:0 ignored): channel n control at 0x00 + 16·n, counter at 0x04 + 16·n, compare at 0x08 + 16·n; start register at 0x80 (any address with bit 7 set). Control layout: bits 2:0 rate code, bit 3 half-width mode (1 = 16-bit), bit 7 match flag, all other bits read zero.

## Requirements
- R1: After reset every counter reads 0, every compare register reads 0xFFFFFFFF, every control register reads 0 (rate code 000, 32-bit mode, flag clear) and the start register reads 0.
- R2: rdata presents, one clock after addr is applied, the register at that address; the start register holds channel run bits in bits 4:0 and changes only through a bus write to it.
- R3: A channel's counter advances only while its start bit is 1; with the bit at 0 the counter keeps its value.
- R4: Rate code 000 gives one increment every 8 clocks, 001 every 32 clocks and 010 every 128 clocks, all timed from one prescaler that starts at reset.
- R5: With a rate code from 011 to 111 the counter does not advance even when the channel is started.
- R6: On a tick where the active counter bits equal the active compare bits, the counter becomes 0 and the match flag (control bit 7, also on match_flag) is set in the same clock.
- R7: Writing 0 to control bit 7 clears the flag; writing 1 leaves it unchanged; a match in the same clock as a clearing write leaves the flag set.
- R8: ovf_pulse of a channel is high for one clock when its counter clears on a match while the compare value is all ones in the active width (0xFFFFFFFF in 32-bit mode, 0xFFFF in its low half in 16-bit mode).
- R9: In 16-bit mode only bits 15:0 of counter and compare take part in counting and matching, reads of counter and compare return 0 in bits 31:16, and bus writes leave bits 31:16 unchanged.
- R10: Channels run independently: rates, periods, modes and flags of one channel do not affect another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register at addr |
| addr | input | 8 | Register byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data for the previous cycle's addr |
| match_flag | output | 5 | Current match flag of each channel |
| ovf_pulse | output | 5 | One-clock overflow pulse per channel |

## Verification
The channel assertions assume one bus access per clock and treat a counter write that lands in the same clock as a match as the write's victory, so the clear-on-match check looks only at flag rises without such a write. They also assume that a flag only falls in response to a control write with bit 7 at zero. The stimulus issues single aligned writes, switches rates and modes only through the control register, and deliberately overlaps flag-clearing writes with matches to exercise the set-wins rule. The reference model in the bench steps the prescaler, counters and flags clock by clock and is compared with rdata, match_flag and ovf_pulse every clock.

// File: rtl/mt_pkg.sv
package mt_pkg;
  // Number of prescaler ratios; code k divides by 2**(3 + 2k)
  localparam int NUM_RATIO = 3;
  localparam int FLAG_BIT  = 7;

  function automatic int ratio_log2(input int code);
    return 3 + 2 * code;
  endfunction

  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_COUNT = 2'd1,
    REG_CMP   = 2'd2
  } reg_sel_e;

  typedef struct packed {
    logic       flag;
    logic [2:0] pad;
    logic       half;
    logic [2:0] rate;
  } ctrl_t;
endpackage

// File: rtl/mt_prescale.sv
module mt_prescale
  import mt_pkg::*;
#(
  parameter int N_RATIO = NUM_RATIO
) (
  input  logic               clk,
  input  logic               rst,
  output logic [N_RATIO-1:0] tick
);
  localparam int PW = ratio_log2(N_RATIO - 1);

  logic [PW-1:0] pcnt;

  always_ff @(posedge clk) begin
    if (rst) pcnt <= '0;
    else     pcnt <= pcnt + PW'(1);
  end

  for (genvar k = 0; k < N_RATIO; k++) begin : g_tick
    localparam int LK = ratio_log2(k);
    assign tick[k] = &pcnt[LK-1:0];

    // Every ratio is at least 8, so a tick never repeats on the next clock
    assert_tick_spacing_R4: assert property (@(posedge clk) disable iff (rst)
      tick[k] |=> !tick[k]);
  end
endmodule

// File: rtl/mt_channel.sv
module mt_channel
  import mt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int HALF_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic [NUM_RATIO-1:0] tick,
  input  logic                 ctrl_we,
  input  logic                 cnt_we,
  input  logic                 cmp_we,
  input  logic [CNT_W-1:0]     wdata,
  output logic [CNT_W-1:0]     ctrl_rd,
  output logic [CNT_W-1:0]     cnt_rd,
  output logic [CNT_W-1:0]     cmp_rd,
  output logic                 flag,
  output logic                 ovf
);
  localparam int UP_W = CNT_W - HALF_W;

  logic [2:0]       rate_q;
  logic             half_q;
  logic [CNT_W-1:0] cnt_q, cmp_q;
  logic [CNT_W-1:0] cnt_act, cmp_act, cnt_inc, cnt_wr, cmp_wr;
  logic             sel_tick, step, hit, all_ones;
  ctrl_t            wv, rv;

  assign wv = ctrl_t'(wdata[7:0]);

  always_comb begin
    sel_tick = 1'b0;
    for (int k = 0; k < NUM_RATIO; k++)
      if (rate_q == 3'(k)) sel_tick = tick[k];
  end

  assign step     = en && sel_tick;
  assign cnt_act  = half_q ? {{UP_W{1'b0}}, cnt_q[HALF_W-1:0]} : cnt_q;
  assign cmp_act  = half_q ? {{UP_W{1'b0}}, cmp_q[HALF_W-1:0]} : cmp_q;
  assign hit      = step && (cnt_act == cmp_act);
  assign all_ones = half_q ? (&cmp_q[HALF_W-1:0]) : (&cmp_q);
  assign cnt_inc  = half_q ? {cnt_q[CNT_W-1:HALF_W], cnt_q[HALF_W-1:0] + HALF_W'(1)}
                           : cnt_q + CNT_W'(1);
  assign cnt_wr   = half_q ? {cnt_q[CNT_W-1:HALF_W], wdata[HALF_W-1:0]} : wdata;
  assign cmp_wr   = half_q ? {cmp_q[CNT_W-1:HALF_W], wdata[HALF_W-1:0]} : wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      rate_q <= '0;
      half_q <= 1'b0;
      cnt_q  <= '0;
      cmp_q  <= '1;
      flag   <= 1'b0;
      ovf    <= 1'b0;
    end else begin
      ovf <= hit && all_ones;
      if (hit)       cnt_q <= '0;
      else if (step) cnt_q <= cnt_inc;
      if (cnt_we)    cnt_q <= cnt_wr;
      if (cmp_we)    cmp_q <= cmp_wr;
      if (ctrl_we) begin
        rate_q <= wv.rate;
        half_q <= wv.half;
      end
      if (hit)                     flag <= 1'b1;
      else if (ctrl_we && !wv.flag) flag <= 1'b0;
    end
  end

  assign rv      = '{flag: flag, pad: 3'b000, half: half_q, rate: rate_q};
  assign ctrl_rd = CNT_W'(rv);
  assign cnt_rd  = cnt_act;
  assign cmp_rd  = cmp_act;

  logic unused_pad;
  assign unused_pad = ^wv.pad;

  assert_hold_stopped_R3: assert property (@(posedge clk) disable iff (rst)
    (!en && !cnt_we) |=> $stable(cnt_q));

  assert_reserved_hold_R5: assert property (@(posedge clk) disable iff (rst)
    ((rate_q >= 3'(NUM_RATIO)) && !cnt_we) |=> $stable(cnt_q));

  assert_clear_on_match_R6: assert property (@(posedge clk) disable iff (rst)
    ($rose(flag) && !$past(cnt_we)) |-> (cnt_q == '0));

  assert_flag_clear_by_zero_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(flag) |-> ($past(ctrl_we) && !$past(wdata[FLAG_BIT])));

  assert_ovf_with_flag_R8: assert property (@(posedge clk) disable iff (rst)
    ovf |-> flag);

  assert_upper_kept_R9: assert property (@(posedge clk) disable iff (rst)
    (half_q && !hit) |=> $stable(cnt_q[CNT_W-1:HALF_W]));
endmodule

// File: rtl/match_timer.sv
module match_timer
  import mt_pkg::*;
#(
  parameter int NUM_CH = 5,
  parameter int CNT_W  = 32,
  parameter int HALF_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  output logic [NUM_CH-1:0] match_flag,
  output logic [NUM_CH-1:0] ovf_pulse
);
  localparam int CH_LSB = 4;
  localparam int CH_W   = ADDR_W - 1 - CH_LSB;

  logic [NUM_RATIO-1:0] tick;
  logic [NUM_CH-1:0]    start_q;
  logic [CNT_W-1:0]     ch_ctrl [NUM_CH];
  logic [CNT_W-1:0]     ch_cnt  [NUM_CH];
  logic [CNT_W-1:0]     ch_cmp  [NUM_CH];
  logic [CNT_W-1:0]     rdata_d;
  logic                 start_hit;
  logic [CH_W-1:0]      ch_sel;
  reg_sel_e             reg_sel;

  assign start_hit = addr[ADDR_W-1];
  assign ch_sel    = addr[ADDR_W-2:CH_LSB];
  assign reg_sel   = reg_sel_e'(addr[3:2]);

  mt_prescale #(.N_RATIO(NUM_RATIO)) u_pre (
    .clk (clk),
    .rst (rst),
    .tick(tick)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic sel;
    assign sel = wr_en && !start_hit && (ch_sel == CH_W'(g));

    mt_channel #(.CNT_W(CNT_W), .HALF_W(HALF_W)) u_ch (
      .clk    (clk),
      .rst    (rst),
      .en     (start_q[g]),
      .tick   (tick),
      .ctrl_we(sel && (reg_sel == REG_CTRL)),
      .cnt_we (sel && (reg_sel == REG_COUNT)),
      .cmp_we (sel && (reg_sel == REG_CMP)),
      .wdata  (wdata),
      .ctrl_rd(ch_ctrl[g]),
      .cnt_rd (ch_cnt[g]),
      .cmp_rd (ch_cmp[g]),
      .flag   (match_flag[g]),
      .ovf    (ovf_pulse[g])
    );
  end

  always_comb begin
    rdata_d = '0;
    if (start_hit) begin
      rdata_d[NUM_CH-1:0] = start_q;
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (ch_sel == CH_W'(c)) begin
          case (reg_sel)
            REG_CTRL:  rdata_d = ch_ctrl[c];
            REG_COUNT: rdata_d = ch_cnt[c];
            REG_CMP:   rdata_d = ch_cmp[c];
            default:   rdata_d = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      rdata   <= '0;
    end else begin
      rdata <= rdata_d;
      if (wr_en && start_hit) start_q <= wdata[NUM_CH-1:0];
    end
  end

  logic unused_addr;
  assign unused_addr = ^addr[1:0];

  assert_start_by_write_R2: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && start_hit) |=> $stable(start_q));
endmodule

// File: tb/match_timer_test.sv
module match_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCH        = 5;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [4:0]  match_flag, ovf_pulse;

  match_timer uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .match_flag(match_flag), .ovf_pulse(ovf_pulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  string tag = "R1";
  int ovf_seen [NCH];

  // Behavioural reference model
  logic [31:0] m_cnt [NCH];
  logic [31:0] m_cmp [NCH];
  int          m_rate [NCH];
  bit          m_half [NCH];
  bit          m_flag [NCH];
  bit          m_ovf  [NCH];
  logic [4:0]  m_start;
  logic [31:0] m_rd;
  longint      m_pre;

  function automatic logic [31:0] model_read(input logic [7:0] a);
    int c;
    if (a[7]) return {27'd0, m_start};
    c = a[6:4];
    if (c >= NCH) return 32'd0;
    case (a[3:2])
      2'd0: return {24'd0, m_flag[c], 3'b000, m_half[c], 3'(m_rate[c])};
      2'd1: return m_half[c] ? (m_cnt[c] & 32'h0000FFFF) : m_cnt[c];
      2'd2: return m_half[c] ? (m_cmp[c] & 32'h0000FFFF) : m_cmp[c];
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      for (int c = 0; c < NCH; c++) begin
        m_cnt[c] = 32'd0; m_cmp[c] = 32'hFFFFFFFF; m_rate[c] = 0;
        m_half[c] = 0; m_flag[c] = 0; m_ovf[c] = 0;
      end
      m_start = '0; m_rd = '0; m_pre = 0;
    end else begin
      bit hitv [NCH];
      m_rd = model_read(addr);
      for (int c = 0; c < NCH; c++) begin
        longint r;
        bit stepv;
        logic [31:0] a, b;
        r = 64'd8 << (2 * m_rate[c]);
        stepv = m_start[c] && (m_rate[c] < 3) && ((m_pre % r) == r - 1);
        a = m_half[c] ? (m_cnt[c] & 32'hFFFF) : m_cnt[c];
        b = m_half[c] ? (m_cmp[c] & 32'hFFFF) : m_cmp[c];
        hitv[c] = stepv && (a == b);
        m_ovf[c] = hitv[c] && (m_half[c] ? ((m_cmp[c] & 32'hFFFF) == 32'hFFFF)
                                         : (m_cmp[c] == 32'hFFFFFFFF));
        if (hitv[c]) begin
          m_cnt[c] = 32'd0;
          m_flag[c] = 1;
        end else if (stepv) begin
          if (m_half[c]) m_cnt[c] = (m_cnt[c] & 32'hFFFF0000) | ((m_cnt[c] + 1) & 32'hFFFF);
          else           m_cnt[c] = m_cnt[c] + 1;
        end
      end
      if (wr_en) begin
        if (addr[7]) m_start = wdata[4:0];
        else if (addr[6:4] < NCH) begin
          int c;
          c = addr[6:4];
          case (addr[3:2])
            2'd0: begin
              m_rate[c] = wdata[2:0];
              m_half[c] = wdata[3];
              if (!hitv[c] && !wdata[7]) m_flag[c] = 0;
            end
            2'd1: m_cnt[c] = m_half[c] ? ((m_cnt[c] & 32'hFFFF0000) | (wdata & 32'hFFFF)) : wdata;
            2'd2: m_cmp[c] = m_half[c] ? ((m_cmp[c] & 32'hFFFF0000) | (wdata & 32'hFFFF)) : wdata;
            default: ;
          endcase
        end
      end
      m_pre++;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // Every-clock comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      check(rdata == m_rd, tag, rdata, m_rd);
      for (int c = 0; c < NCH; c++) begin
        check(match_flag[c] == m_flag[c], "R7", 32'(match_flag[c]), 32'(m_flag[c]));
        check(ovf_pulse[c] == m_ovf[c], "R8", 32'(ovf_pulse[c]), 32'(m_ovf[c]));
        if (ovf_pulse[c]) ovf_seen[c]++;
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > WATCHDOG) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_lit(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    check(rdata == exp, req, rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] first;
    for (int c = 0; c < NCH; c++) ovf_seen[c] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    tag = "R1";
    rd_lit(8'h00, 32'h0, "R1");
    rd_lit(8'h04, 32'h0, "R1");
    rd_lit(8'h08, 32'hFFFFFFFF, "R1");
    rd_lit(8'h48, 32'hFFFFFFFF, "R1");
    rd_lit(8'h80, 32'h0, "R1");

    tag = "R6";
    wr(8'h08, 32'd5);
    wr(8'h00, 32'h0);
    wr(8'h80, 32'h01);
    rd_lit(8'h80, 32'h01, "R2");
    idle(100);
    check(match_flag[0] == 1'b1, "R6", 32'(match_flag[0]), 32'h1);

    tag = "R7";
    wr(8'h80, 32'h00);
    wr(8'h00, 32'h80);
    check(match_flag[0] == 1'b1, "R7", 32'(match_flag[0]), 32'h1);
    wr(8'h00, 32'h00);
    check(match_flag[0] == 1'b0, "R7", 32'(match_flag[0]), 32'h0);

    tag = "R3";
    @(negedge clk); addr = 8'h04;
    @(negedge clk); first = rdata;
    idle(60);
    check(rdata == first, "R3", rdata, first);

    tag = "R4";
    wr(8'h18, 32'd1000);
    wr(8'h10, 32'h1);
    wr(8'h28, 32'd1000);
    wr(8'h20, 32'h2);
    wr(8'h80, 32'h06);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); addr = 8'h14;
      idle(60);
      @(negedge clk); addr = 8'h24;
      idle(60);
    end

    tag = "R5";
    wr(8'h30, 32'h3);
    wr(8'h80, 32'h0E);
    idle(300);
    rd_lit(8'h34, 32'h0, "R5");
    wr(8'h30, 32'h7);
    idle(300);
    rd_lit(8'h34, 32'h0, "R5");

    tag = "R9";
    wr(8'h40, 32'h8);
    wr(8'h48, 32'h12340007);
    rd_lit(8'h48, 32'h00000007, "R9");
    wr(8'h44, 32'hABCD0003);
    rd_lit(8'h44, 32'h00000003, "R9");
    rd_lit(8'h40, 32'h00000008, "R9");

    tag = "R8";
    wr(8'h48, 32'h0000FFFF);
    wr(8'h44, 32'h0000FFFC);
    wr(8'h80, 32'h1E);
    idle(100);
    check(ovf_seen[4] > 0, "R8", 32'(ovf_seen[4]), 32'h1);
    wr(8'h80, 32'h0E);
    wr(8'h08, 32'hFFFFFFFF);
    wr(8'h04, 32'hFFFFFFFD);
    wr(8'h80, 32'h0F);
    idle(60);
    check(ovf_seen[0] > 0, "R8", 32'(ovf_seen[0]), 32'h1);

    tag = "R10";
    wr(8'h28, 32'h0);
    wr(8'h20, 32'h0);
    @(negedge clk);
    wr_en = 1'b1; addr = 8'h20; wdata = 32'h0;
    repeat (40) @(negedge clk);
    wr_en = 1'b0;
    idle(20);
    rd_lit(8'h10, 32'h00000001 | (32'(m_flag[1]) << 7), "R10");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule